// File: doc/BRIEF.md
# Window Watchdog with Merged Enable Control

This block is a window watchdog timer for a supply supervisor. A host must toggle a kick input once in each frame. A frame is a closed window, in which a kick is forbidden, followed by an open window, in which a kick is expected. A kick that comes too early, or an open window that ends with no kick, counts as a violation. On a violation the active-low watchdog output `wdo_no_o` is pulled low for a fixed number of cycles. The output is then released and a fresh frame begins.

Three sources can switch monitoring off. The first is either an enable pin or a two-bit mode code; a build parameter selects which one the build uses. The second is a configuration-disable flag, which outranks the first. The flag is sampled only after reset, after an undervoltage fault ends, and after a manual reset is released. Whenever monitoring is off, or the supervisor holds the block idle, the output stays high and the frame is dropped. When monitoring comes back on, a new closed window starts at once.

Top module: `wwdt_top`

## Requirements
- R1: After reset the output `wdo_no_o` is high (deasserted).
- R2: A kick rising edge seen during the closed window (CLOSE_CYC cycles long) is a violation and pulls `wdo_no_o` low. A kick driven before clock edge d, counting edge 0 as the first edge with monitoring on, is seen at edge d+2.
- R3: A kick seen during the open window (OPEN_CYC cycles long) ends the frame without a violation and starts a new closed window.
- R4: When the open window runs out with no kick, `wdo_no_o` goes low at edge CLOSE_CYC+OPEN_CYC+1, counting from the enable edge.
- R5: A violation holds `wdo_no_o` low for exactly FAULT_CYC cycles. The output is then released and a new closed window begins.
- R6: In the pin build, `wd_en_i` high turns monitoring on and low turns it off. Turning it off drops any frame or low pulse in progress, and `wdo_no_o` is high within two cycles and stays high while off.
- R7: Every time monitoring turns on, the frame restarts in the closed window, with the timing of R2 and R4.
- R8: In the mode-code build, `set_i == 2'b01` turns monitoring off and any other code turns it on. `wd_en_i` has no effect in that build.
- R9: When the latched configuration-disable flag is 1, monitoring is off whatever the other sources say. `cfg_dis_i` is sampled only in the first cycle after reset, after `uv_fault_i` falls, or after `mr_ni` rises. A change at any other time is ignored.
- R10: While `uv_fault_i` is high or `mr_ni` is low, the block is idle with `wdo_no_o` high. After release, monitoring on is first seen one edge after the sampling edge.
- R11: Only a rising edge of `kick_i`, after a two-flop synchronizer, counts. A kick held high counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| kick_i | input | 1 | Host kick, asynchronous |
| wd_en_i | input | 1 | Monitoring enable, pin build |
| set_i | input | 2 | Mode code, mode-code build; 2'b01 = off |
| cfg_dis_i | input | 1 | Configuration-disable flag, sampled at recovery |
| uv_fault_i | input | 1 | Undervoltage fault, forces idle |
| mr_ni | input | 1 | Manual reset, active low, forces idle |
| wdo_no_o | output | 1 | Watchdog fault output, active low |

## Verification
The properties assume that the enable, mode and configuration inputs are synchronous to the clock. The kick input is the only one that may arrive at any time. They also assume that the supervisor hold inputs are held for at least one full cycle. The bench changes every input at the falling clock edge, so each input is stable at the rising edge. It also holds `uv_fault_i` and `mr_ni` for at least one whole cycle, so each hold is captured and each release starts exactly one sampling cycle.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
  typedef enum logic [1:0] {
    WD_IDLE   = 2'd0,
    WD_CLOSED = 2'd1,
    WD_OPEN   = 2'd2,
    WD_FAULT  = 2'd3
  } wd_state_e;

  localparam logic [1:0] WD_OFF_CODE = 2'b01;

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/wwdt_kick_edge.sv
module wwdt_kick_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic pulse_o
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], kick_i};
  end

  assign pulse_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/wwdt_en_ctrl.sv
module wwdt_en_ctrl
  import wwdt_pkg::*;
#(
  parameter bit USE_EN_PIN = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wd_en_i,
  input  logic [1:0] set_i,
  input  logic       cfg_dis_i,
  input  logic       hold_i,
  output logic       en_o,
  output logic       need_sample_o,
  output logic       cfg_lat_o
);
  logic sel_en;
  logic need_sample_q, cfg_lat_q, en_q;
  logic unused_in;

  assign unused_in = ^{set_i, wd_en_i};

  generate
    if (USE_EN_PIN) begin : g_pin
      assign sel_en = wd_en_i;
    end else begin : g_code
      assign sel_en = (set_i != WD_OFF_CODE);
    end
  endgenerate

  // config flag re-sampled in first free cycle after reset or a hold
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      need_sample_q <= 1'b1;
      cfg_lat_q     <= 1'b0;
      en_q          <= 1'b0;
    end else begin
      if (hold_i) begin
        need_sample_q <= 1'b1;
      end else if (need_sample_q) begin
        need_sample_q <= 1'b0;
        cfg_lat_q     <= cfg_dis_i;
      end
      en_q <= ~hold_i & ~need_sample_q & ~cfg_lat_q & sel_en;
    end
  end

  assign en_o          = en_q;
  assign need_sample_o = need_sample_q;
  assign cfg_lat_o     = cfg_lat_q;
endmodule

// File: rtl/wwdt_window.sv
module wwdt_window
  import wwdt_pkg::*;
#(
  parameter int CLOSE_CYC = 8,
  parameter int OPEN_CYC  = 8,
  parameter int FAULT_CYC = 4,
  parameter int CNT_W     = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      kick_i,
  output wd_state_e state_o,
  output logic      wdo_no_o
);
  localparam logic [CNT_W-1:0] CLOSE_LAST = CNT_W'(CLOSE_CYC - 1);
  localparam logic [CNT_W-1:0] OPEN_LAST  = CNT_W'(OPEN_CYC - 1);
  localparam logic [CNT_W-1:0] FAULT_LAST = CNT_W'(FAULT_CYC - 1);

  wd_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WD_IDLE;
      cnt_q   <= '0;
    end else if (!en_i) begin
      state_q <= WD_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        WD_IDLE: begin
          state_q <= WD_CLOSED;
          cnt_q   <= '0;
        end
        WD_CLOSED: begin
          if (kick_i) begin
            state_q <= WD_FAULT;
            cnt_q   <= '0;
          end else if (cnt_q == CLOSE_LAST) begin
            state_q <= WD_OPEN;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        WD_OPEN: begin
          if (kick_i) begin
            state_q <= WD_CLOSED;
            cnt_q   <= '0;
          end else if (cnt_q == OPEN_LAST) begin
            state_q <= WD_FAULT;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        WD_FAULT: begin
          if (cnt_q == FAULT_LAST) begin
            state_q <= WD_CLOSED;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          state_q <= WD_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign state_o  = state_q;
  assign wdo_no_o = (state_q != WD_FAULT);
endmodule

// File: rtl/wwdt_top.sv
module wwdt_top
  import wwdt_pkg::*;
#(
  parameter bit USE_EN_PIN  = 1'b1,
  parameter int CLOSE_CYC   = 8,
  parameter int OPEN_CYC    = 8,
  parameter int FAULT_CYC   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       kick_i,
  input  logic       wd_en_i,
  input  logic [1:0] set_i,
  input  logic       cfg_dis_i,
  input  logic       uv_fault_i,
  input  logic       mr_ni,
  output logic       wdo_no_o
);
  localparam int MAX_CYC = max3(CLOSE_CYC, OPEN_CYC, FAULT_CYC);
  localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  logic      hold, en_q, kick_pulse, need_sample, cfg_lat;
  wd_state_e state;

  assign hold = uv_fault_i | ~mr_ni;

  wwdt_kick_edge #(.STAGES(SYNC_STAGES)) u_kick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .kick_i (kick_i),
    .pulse_o(kick_pulse)
  );

  wwdt_en_ctrl #(.USE_EN_PIN(USE_EN_PIN)) u_en (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wd_en_i      (wd_en_i),
    .set_i        (set_i),
    .cfg_dis_i    (cfg_dis_i),
    .hold_i       (hold),
    .en_o         (en_q),
    .need_sample_o(need_sample),
    .cfg_lat_o    (cfg_lat)
  );

  wwdt_window #(
    .CLOSE_CYC(CLOSE_CYC),
    .OPEN_CYC (OPEN_CYC),
    .FAULT_CYC(FAULT_CYC),
    .CNT_W    (CNT_W)
  ) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_q),
    .kick_i  (kick_pulse),
    .state_o (state),
    .wdo_no_o(wdo_no_o)
  );
endmodule

// File: rtl/wwdt_chk.sv
module wwdt_chk
  import wwdt_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      en_q,
  input logic      hold,
  input logic      kick_pulse,
  input logic      need_sample,
  input logic      cfg_lat,
  input wd_state_e state,
  input logic      wdo_no_o
);
  AST_CLOSED_KICK_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && state == WD_CLOSED && kick_pulse) |=> state == WD_FAULT); // R2

  AST_OPEN_KICK_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && state == WD_OPEN && kick_pulse) |=> state == WD_CLOSED); // R3

  AST_OFF_WDO_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> wdo_no_o); // R6

  AST_ON_CLOSED_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_q) |=> state == WD_CLOSED); // R7

  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!need_sample && !hold) |=> $stable(cfg_lat)); // R9

  AST_CFG_OVERRIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_lat && !need_sample) |=> !en_q); // R9

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold |=> !en_q); // R10

  AST_KICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_pulse |=> !kick_pulse); // R11
endmodule

bind wwdt_top wwdt_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_q       (en_q),
  .hold       (hold),
  .kick_pulse (kick_pulse),
  .need_sample(need_sample),
  .cfg_lat    (cfg_lat),
  .state      (state),
  .wdo_no_o   (wdo_no_o)
);

// File: tb/tb_wwdt_top.sv
module tb_wwdt_top;
  localparam int CLK_PERIOD = 10;
  localparam int C = 8;
  localparam int O = 8;
  localparam int F = 4;
  localparam int NVEC = 8;
  // {kick edge offset d (-1 = none), first edge with wdo low (-1 = none)}
  localparam int VEC [NVEC][2] = '{
    '{-1, C+O+1}, '{0, 2}, '{3, 5}, '{C-1, C+1},
    '{C, -1}, '{C+3, -1}, '{C+O-1, -1}, '{C+O, C+O+1}
  };

  logic clk = 1'b0;
  logic rst_n, kick, wd_en, cfg_dis, uv, mr_n, wdo_n;
  logic [1:0] set_c;
  logic wd_en_s, wdo_s;
  logic [1:0] set_s;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wwdt_top #(.USE_EN_PIN(1'b1), .CLOSE_CYC(C), .OPEN_CYC(O), .FAULT_CYC(F)) dut (
    .clk_i(clk), .rst_ni(rst_n), .kick_i(kick), .wd_en_i(wd_en), .set_i(set_c),
    .cfg_dis_i(cfg_dis), .uv_fault_i(uv), .mr_ni(mr_n), .wdo_no_o(wdo_n)
  );

  wwdt_top #(.USE_EN_PIN(1'b0), .CLOSE_CYC(C), .OPEN_CYC(O), .FAULT_CYC(F)) dut_s (
    .clk_i(clk), .rst_ni(rst_n), .kick_i(1'b0), .wd_en_i(wd_en_s), .set_i(set_s),
    .cfg_dis_i(1'b0), .uv_fault_i(1'b0), .mr_ni(1'b1), .wdo_no_o(wdo_s)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // enable at this negedge; edge 0 is the next posedge; returns first low edge
  task automatic frame(input int d, input int span, input bit hold_kick, output int first);
    first = -1;
    wd_en = 1'b1;
    kick = (d == 0);
    for (int i = 0; i <= span; i++) begin
      tick();
      if (hold_kick) kick = (i + 1 >= d) ? 1'b1 : kick;
      else           kick = (i + 1 == d);
      if (!wdo_n && first < 0) first = i;
    end
  endtask

  task automatic count_low(input int n, input bit sel, output int lows);
    lows = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (!(sel ? wdo_s : wdo_n)) lows++;
    end
  endtask

  task automatic off_idle();
    wd_en = 1'b0;
    kick = 1'b0;
    repeat (4) tick();
  endtask

  initial begin
    int first, lows;
    rst_n = 1'b0; kick = 1'b0; wd_en = 1'b0; set_c = 2'b00; cfg_dis = 1'b0;
    uv = 1'b0; mr_n = 1'b1; wd_en_s = 1'b1; set_s = 2'b01;
    repeat (3) @(negedge clk);
    chk(wdo_n == 1'b1, "R1 reset", wdo_n, 1);
    rst_n = 1'b1;
    repeat (3) tick();
    chk(wdo_n == 1'b1 && wdo_s == 1'b1, "R1 after reset", {wdo_n, wdo_s}, 3);

    // vector table: R2 closed kicks, R3 open kicks, R4 expiry, R7 restart
    for (int v = 0; v < NVEC; v++) begin
      off_idle();
      frame(VEC[v][0], C+O+3, 1'b0, first);
      chk(first == VEC[v][1], "R2/R3/R4/R7 window vector", first, VEC[v][1]);
    end

    // R5: fault length and new closed window
    off_idle();
    frame(-1, C+O+1, 1'b0, first);
    chk(first == C+O+1, "R4 expiry", first, C+O+1);
    count_low(F-1, 1'b0, lows);
    chk(lows == F-1, "R5 low span", lows, F-1);
    tick();
    chk(wdo_n == 1'b1, "R5 release", wdo_n, 1);
    count_low(C+O-1, 1'b0, lows);
    chk(lows == 0, "R5 new closed window quiet", lows, 0);
    tick();
    chk(wdo_n == 1'b0, "R5 next expiry", wdo_n, 0);

    // R6: disable mid-fault
    wd_en = 1'b0;
    tick(); tick();
    chk(wdo_n == 1'b1, "R6 off clears fault", wdo_n, 1);
    count_low(40, 1'b0, lows);
    chk(lows == 0, "R6 stays high while off", lows, 0);

    // R11: kick held high from open window counts once
    off_idle();
    frame(C, C+O+3, 1'b1, first);
    chk(first == -1, "R11 held kick single", first, -1);
    kick = 1'b0;

    // R9: cfg change while running ignored
    off_idle();
    wd_en = 1'b1;
    repeat (2) tick();
    cfg_dis = 1'b1;
    off_idle();
    frame(-1, C+O+3, 1'b0, first);
    chk(first == C+O+1, "R9 cfg change ignored", first, C+O+1);
    // manual reset: resample -> disabled
    mr_n = 1'b0;
    tick();
    mr_n = 1'b1;
    repeat (3) tick();
    count_low(40, 1'b0, lows);
    chk(lows == 0, "R9 cfg override after mr", lows, 0);
    cfg_dis = 1'b0;
    count_low(40, 1'b0, lows);
    chk(lows == 0, "R9 cfg clear ignored", lows, 0);

    // R10: uv hold idles block, release resamples and restarts
    uv = 1'b1;
    tick();
    chk(wdo_n == 1'b1, "R10 hold high", wdo_n, 1);
    count_low(30, 1'b0, lows);
    chk(lows == 0, "R10 hold quiet", lows, 0);
    uv = 1'b0;
    first = -1;
    for (int i = 0; i <= C+O+4; i++) begin
      tick();
      if (!wdo_n && first < 0) first = i;
    end
    chk(first == C+O+2, "R10 recovery restart", first, C+O+2);

    // R10: hold during fault forces high
    off_idle();
    frame(-1, C+O+1, 1'b0, first);
    uv = 1'b1;
    tick(); tick();
    chk(wdo_n == 1'b1, "R10 hold clears fault", wdo_n, 1);
    uv = 1'b0;
    off_idle();

    // R8: code build
    count_low(40, 1'b1, lows);
    chk(lows == 0, "R8 code 01 off, pin ignored", lows, 0);
    set_s = 2'b10;
    first = -1;
    for (int i = 0; i <= C+O+3; i++) begin
      tick();
      if (!wdo_s && first < 0) first = i;
    end
    chk(first == C+O+1, "R8 code 10 on", first, C+O+1);
    set_s = 2'b01;
    tick(); tick();
    chk(wdo_s == 1'b1, "R8 code 01 aborts", wdo_s, 1);
    count_low(4, 1'b1, lows);
    wd_en_s = 1'b0;
    set_s = 2'b11;
    first = -1;
    for (int i = 0; i <= C+O+3; i++) begin
      tick();
      if (!wdo_s && first < 0) first = i;
    end
    chk(first == C+O+1, "R8 pin low ignored", first, C+O+1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog timeout actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule